// File: doc/BRIEF.md
# Push-Only Crossbar Transfer Scheduler

This block schedules transfers across a small on-chip crossbar of client ports. Each port has a separate inbound path (the data it sends) and a separate outbound path (the data it receives), so one port can send and receive at the same time. Data only moves in one direction: an initiator asks to push a burst to a destination, and the scheduler decides when that may happen. Nothing crosses the switch as a read request.

An initiator holds a request that names a destination, a lane (high or low priority), a transfer type and a burst length. The scheduler waits until the destination is not already receiving, shows readiness on the requested lane, and at least one internal datapath is free. It then pulses a grant back to the initiator. In the same cycle it pulses a notice to the destination that carries the initiator's port number, the type and the lane. The initiator puts its beats on its inbound data bus in the cycles after the grant. The scheduler steers them onto the destination's outbound bus over the internal datapath it assigned. It frees the datapath and the destination after the last beat. At most one grant is issued per cycle. High-priority requests go first, and a round-robin pointer for each lane keeps any initiator from starving.

Top module: `xbar_sched`

## Requirements
- R1: A request is granted only while its destination shows ready on the request's lane (`dst_rdy_hi` for `req_hi`=1, `dst_rdy_lo` for `req_hi`=0), the destination is not receiving, the initiator is not sending, and an internal datapath is free; otherwise it stays pending.
- R2: `gnt` is a one-cycle pulse, registered: a request evaluated in cycle t shows `gnt` in cycle t+1, and at most one bit of `gnt` is set in any cycle.
- R3: In the cycle `gnt[p]` is high, `ntf_valid[d]` is high for the requested destination d, with `ntf_src[d]`=p, `ntf_type[d]` equal to the request's type and `ntf_hi[d]` equal to its lane; no notice is raised without a grant.
- R4: When a high-lane request and a low-lane request are both grantable in the same cycle, the high-lane request is granted.
- R5: Within a lane, grantable initiators are served round-robin by port index, starting from the port after the lane's last winner (both pointers start at port 0 after reset).
- R6: `req_len` encodes beats minus one (0 to 3 means 1 to 4 beats). For a grant seen in cycle g, beat k (k=0..len) appears in cycle g+1+k with `out_valid[d]`=1 and `out_data[d]` equal to `in_data[p]` of that cycle; `out_valid` is low on ports that receive nothing.
- R7: The destination and the datapath stay held through the last beat. With a single-beat transfer granted in cycle g, another request to that destination can be granted no earlier than cycle g+3.
- R8: No more than NPATHS transfers are in flight. With 4-beat transfers and all datapaths busy, a waiting request is granted 6 cycles after the grant that took the first of those datapaths.
- R9: A request whose destination equals its own port is never granted; `err` for that port pulses for one cycle, in the cycle after the request first appears.
- R10: Lanes are sampled per destination: a destination with its low lane stalled still accepts high-lane transfers, and a low-lane request to it waits until its low lane is ready.
- R11: During reset `gnt`, `err`, `ntf_valid` and `out_valid` are all low, whatever the request inputs are.
- R12: A port can send and receive at once: two ports pushing to each other are granted in consecutive cycles and their transfers overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NPORTS | Request held by each initiator until granted |
| req_dst | input | NPORTS x IDW | Destination port of each request |
| req_hi | input | NPORTS | Lane of each request: 1 high, 0 low |
| req_type | input | NPORTS x TW | Transfer type, passed to the destination |
| req_len | input | NPORTS x LW | Burst length minus one |
| gnt | output | NPORTS | One-cycle grant to the initiator |
| err | output | NPORTS | One-cycle pulse for a request to the initiator's own port |
| in_data | input | NPORTS x DW | Beats driven by each initiator after its grant |
| dst_rdy_hi | input | NPORTS | Destination accepts a high-lane transfer |
| dst_rdy_lo | input | NPORTS | Destination accepts a low-lane transfer |
| ntf_valid | output | NPORTS | One-cycle notice to a destination at grant time |
| ntf_src | output | NPORTS x IDW | Initiator port of the notified transfer |
| ntf_type | output | NPORTS x TW | Type of the notified transfer |
| ntf_hi | output | NPORTS | Lane of the notified transfer |
| out_valid | output | NPORTS | A beat is present on the destination's outbound bus |
| out_data | output | NPORTS x DW | Outbound beat data |

## Verification
A datapath counter that is off by one shows up within one burst: a beat goes missing or an extra `out_valid` cycle appears on the destination, and the data tags carry the beat index. A leaked busy flag on a datapath, a destination or an initiator shows up as a request that stays pending. The watch on request age catches it within a few hundred cycles. A bad lane or pointer register shows up on the very next contested grant, as the wrong port in `gnt` and in `ntf_src`. The directed cases time each grant to the exact cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    int k;
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      k = int'(ptr) + i;
      if (k >= N) k = k - N;
      if (!found && cand[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/xbar_path_pool.sv
module xbar_path_pool #(
  parameter int NPORTS = 8,
  parameter int NPATHS = 8,
  parameter int LW     = 2
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           alloc,
  input  logic [xbar_pkg::idx_width(NPORTS)-1:0]         alloc_src,
  input  logic [xbar_pkg::idx_width(NPORTS)-1:0]         alloc_dst,
  input  logic [LW-1:0]                                  alloc_len,
  output logic                                           path_free,
  output logic [NPORTS-1:0]                              src_busy,
  output logic [NPORTS-1:0]                              dst_busy,
  output logic [NPORTS-1:0]                              route_vld,
  output logic [NPORTS-1:0][xbar_pkg::idx_width(NPORTS)-1:0] route_src
);
  localparam int IDW = xbar_pkg::idx_width(NPORTS);
  localparam int PIW = xbar_pkg::idx_width(NPATHS);

  logic [NPATHS-1:0]          busy_q, busy_n, run_q, run_n;
  logic [NPATHS-1:0][LW-1:0]  left_q, left_n;
  logic [NPATHS-1:0][IDW-1:0] src_q, dst_q;
  logic [PIW-1:0]             sel;
  logic [NPORTS-1:0][NPATHS-1:0] src_hit, dst_hit;

  // lowest free datapath
  always_comb begin
    sel       = '0;
    path_free = 1'b0;
    for (int i = NPATHS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        sel       = PIW'(i);
        path_free = 1'b1;
      end
    end
  end

  // datapath life: armed in grant cycle, then carries len+1 beats
  always_comb begin
    busy_n = busy_q;
    run_n  = run_q;
    left_n = left_q;
    for (int i = 0; i < NPATHS; i++) begin
      if (busy_q[i]) begin
        if (!run_q[i]) begin
          run_n[i] = 1'b1;
        end else if (left_q[i] == '0) begin
          busy_n[i] = 1'b0;
          run_n[i]  = 1'b0;
        end else begin
          left_n[i] = left_q[i] - 1'b1;
        end
      end
    end
    if (alloc) begin
      busy_n[sel] = 1'b1;
      run_n[sel]  = 1'b0;
      left_n[sel] = alloc_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      run_q  <= '0;
    end else begin
      busy_q <= busy_n;
      run_q  <= run_n;
    end
  end

  always_ff @(posedge clk) begin
    left_q <= left_n;
    if (alloc) begin
      src_q[sel] <= alloc_src;
      dst_q[sel] <= alloc_dst;
    end
  end

  // occupancy and routing views
  always_comb begin
    src_hit   = '0;
    dst_hit   = '0;
    route_vld = '0;
    route_src = '0;
    for (int i = 0; i < NPATHS; i++) begin
      if (busy_q[i]) begin
        src_hit[src_q[i]][i] = 1'b1;
        dst_hit[dst_q[i]][i] = 1'b1;
        if (run_q[i]) begin
          route_vld[dst_q[i]] = 1'b1;
          route_src[dst_q[i]] = src_q[i];
        end
      end
    end
    for (int p = 0; p < NPORTS; p++) begin
      src_busy[p] = |src_hit[p];
      dst_busy[p] = |dst_hit[p];
    end
  end

  // R8
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> path_free);

  for (genvar g = 0; g < NPORTS; g++) begin : g_port_chk
    // R7
    dst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dst_hit[g]));
    // R12
    src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_hit[g]));
  end

  for (genvar g = 0; g < NPATHS; g++) begin : g_path_chk
    // R6
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[g] && run_q[g] && left_q[g] != '0) |=> busy_q[g]);
  end
endmodule

// File: rtl/xbar_sched.sv
module xbar_sched #(
  parameter int NPORTS = 8,
  parameter int NPATHS = 8,
  parameter int DW     = 32,
  parameter int TW     = 2,
  parameter int LW     = 2
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic [NPORTS-1:0]                                  req_valid,
  input  logic [NPORTS-1:0][xbar_pkg::idx_width(NPORTS)-1:0] req_dst,
  input  logic [NPORTS-1:0]                                  req_hi,
  input  logic [NPORTS-1:0][TW-1:0]                          req_type,
  input  logic [NPORTS-1:0][LW-1:0]                          req_len,
  output logic [NPORTS-1:0]                                  gnt,
  output logic [NPORTS-1:0]                                  err,
  input  logic [NPORTS-1:0][DW-1:0]                          in_data,
  input  logic [NPORTS-1:0]                                  dst_rdy_hi,
  input  logic [NPORTS-1:0]                                  dst_rdy_lo,
  output logic [NPORTS-1:0]                                  ntf_valid,
  output logic [NPORTS-1:0][xbar_pkg::idx_width(NPORTS)-1:0] ntf_src,
  output logic [NPORTS-1:0][TW-1:0]                          ntf_type,
  output logic [NPORTS-1:0]                                  ntf_hi,
  output logic [NPORTS-1:0]                                  out_valid,
  output logic [NPORTS-1:0][DW-1:0]                          out_data
);
  import xbar_pkg::*;
  localparam int IDW = idx_width(NPORTS);

  logic                  rst_s_n;
  logic [NPORTS-1:0]     self_req, lane_ok, cand, cand_hi, cand_lo;
  logic                  hi_found, lo_found, alloc, path_free;
  logic [IDW-1:0]        hi_idx, lo_idx, win, win_dst;
  lane_e                 win_lane;
  logic [NPORTS-1:0]     src_busy, dst_busy, route_vld;
  logic [NPORTS-1:0][IDW-1:0] route_src;

  logic [NPORTS-1:0]     gnt_q, gnt_n, ntf_valid_q, ntf_valid_n, err_q, err_n, self_q;
  logic [IDW-1:0]        rr_hi_q, rr_hi_n, rr_lo_q, rr_lo_n;
  logic [NPORTS-1:0][IDW-1:0] ntf_src_q;
  logic [NPORTS-1:0][TW-1:0]  ntf_type_q;
  logic [NPORTS-1:0]          ntf_hi_q;

  function automatic logic [IDW-1:0] after(logic [IDW-1:0] i);
    return (i == IDW'(NPORTS - 1)) ? '0 : i + 1'b1;
  endfunction

  xbar_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  // eligibility of each initiator
  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      self_req[p] = req_valid[p] && (req_dst[p] == IDW'(p));
      lane_ok[p]  = req_hi[p] ? dst_rdy_hi[req_dst[p]] : dst_rdy_lo[req_dst[p]];
      cand[p]     = req_valid[p] && !self_req[p] && !src_busy[p] &&
                    !dst_busy[req_dst[p]] && lane_ok[p] && path_free;
    end
    cand_hi = cand & req_hi;
    cand_lo = cand & ~req_hi;
  end

  xbar_rr_pick #(.N(NPORTS), .IW(IDW)) u_pick_hi (
    .cand(cand_hi), .ptr(rr_hi_q), .found(hi_found), .idx(hi_idx));
  xbar_rr_pick #(.N(NPORTS), .IW(IDW)) u_pick_lo (
    .cand(cand_lo), .ptr(rr_lo_q), .found(lo_found), .idx(lo_idx));

  always_comb begin
    alloc    = hi_found || lo_found;
    win      = hi_found ? hi_idx : lo_idx;
    win_lane = hi_found ? LANE_HI : LANE_LO;
    win_dst  = req_dst[win];
  end

  xbar_path_pool #(.NPORTS(NPORTS), .NPATHS(NPATHS), .LW(LW)) u_pool (
    .clk(clk), .rst_n(rst_s_n), .alloc(alloc), .alloc_src(win),
    .alloc_dst(win_dst), .alloc_len(req_len[win]), .path_free(path_free),
    .src_busy(src_busy), .dst_busy(dst_busy), .route_vld(route_vld),
    .route_src(route_src));

  // next state
  always_comb begin
    gnt_n       = '0;
    ntf_valid_n = '0;
    rr_hi_n     = rr_hi_q;
    rr_lo_n     = rr_lo_q;
    if (alloc) begin
      gnt_n[win]           = 1'b1;
      ntf_valid_n[win_dst] = 1'b1;
      if (win_lane == LANE_HI) rr_hi_n = after(win);
      else                     rr_lo_n = after(win);
    end
    err_n = self_req & ~self_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      gnt_q       <= '0;
      ntf_valid_q <= '0;
      err_q       <= '0;
      self_q      <= '0;
      rr_hi_q     <= '0;
      rr_lo_q     <= '0;
    end else begin
      gnt_q       <= gnt_n;
      ntf_valid_q <= ntf_valid_n;
      err_q       <= err_n;
      self_q      <= self_req;
      rr_hi_q     <= rr_hi_n;
      rr_lo_q     <= rr_lo_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int d = 0; d < NPORTS; d++) begin
      if (alloc && win_dst == IDW'(d)) begin
        ntf_src_q[d]  <= win;
        ntf_type_q[d] <= req_type[win];
        ntf_hi_q[d]   <= (win_lane == LANE_HI);
      end
    end
  end

  // outbound steering
  always_comb begin
    for (int d = 0; d < NPORTS; d++) begin
      out_valid[d] = route_vld[d];
      out_data[d]  = route_vld[d] ? in_data[route_src[d]] : '0;
    end
  end

  assign gnt       = gnt_q;
  assign err       = err_q;
  assign ntf_valid = ntf_valid_q;
  assign ntf_src   = ntf_src_q;
  assign ntf_type  = ntf_type_q;
  assign ntf_hi    = ntf_hi_q;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(gnt_q));
  // R3
  ntf_pair_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones(gnt_q) == $countones(ntf_valid_q));
  // R4
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|gnt_q && !(|(ntf_valid_q & ntf_hi_q))) |-> $past(!hi_found));
  // R9
  self_never_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (gnt_q & $past(self_req)) == '0);

  for (genvar g = 0; g < NPORTS; g++) begin : g_rdy_chk
    // R1
    ready_seen_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      ntf_valid_q[g] |-> (ntf_hi_q[g] ? $past(dst_rdy_hi[g]) : $past(dst_rdy_lo[g])));
  end
endmodule

// File: tb/tb_xbar_sched.sv
`timescale 1ns/1ps
module tb_xbar_sched;
  localparam int N   = 8;
  localparam int NP  = 3;
  localparam int DW  = 32;
  localparam int TW  = 2;
  localparam int LW  = 2;
  localparam int IDW = 3;

  logic clk, rst_n;
  logic [N-1:0]          req_valid, req_hi, gnt, err, dst_rdy_hi, dst_rdy_lo;
  logic [N-1:0][IDW-1:0] req_dst, ntf_src;
  logic [N-1:0][TW-1:0]  req_type, ntf_type;
  logic [N-1:0][LW-1:0]  req_len;
  logic [N-1:0][DW-1:0]  in_data, out_data;
  logic [N-1:0]          ntf_valid, ntf_hi, out_valid;

  xbar_sched #(.NPORTS(N), .NPATHS(NP), .DW(DW), .TW(TW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .req_hi(req_hi), .req_type(req_type), .req_len(req_len), .gnt(gnt),
    .err(err), .in_data(in_data), .dst_rdy_hi(dst_rdy_hi),
    .dst_rdy_lo(dst_rdy_lo), .ntf_valid(ntf_valid), .ntf_src(ntf_src),
    .ntf_type(ntf_type), .ntf_hi(ntf_hi), .out_valid(out_valid),
    .out_data(out_data));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, gp;
  bit rnd = 0;
  bit pend[N], act[N], phi[N];
  int pdst[N], plen[N], ptype[N], bi[N], pwait[N];
  logic [15:0] salt[N];

  function automatic logic [DW-1:0] mk(int p, int b, logic [15:0] s);
    return {8'(p), 8'(b), s};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint a, longint e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, a, e, cyc);
    end
  endtask

  task automatic issue(int p, int d, bit hi, int ty, int len);
    req_valid[p] = 1'b1; req_dst[p] = IDW'(d); req_hi[p] = hi;
    req_type[p] = TW'(ty); req_len[p] = LW'(len);
    pend[p] = 1; pdst[p] = d; phi[p] = hi; ptype[p] = ty; plen[p] = len;
    pwait[p] = 0; salt[p] = 16'($urandom);
  endtask

  task automatic step();
    int nact, d;
    bit seen;
    @(negedge clk);
    cyc++;
    // beats in flight (R6)
    for (int q = 0; q < N; q++) begin
      seen = 0;
      for (int p = 0; p < N; p++) begin
        if (act[p] && pdst[p] == q) begin
          seen = 1;
          chk(out_valid[q] == 1'b1, "R6", "out_valid during beat", out_valid[q], 1);
          chk(out_data[q] == mk(p, bi[p], salt[p]), "R6", "beat data", out_data[q], mk(p, bi[p], salt[p]));
        end
      end
      if (!seen && out_valid[q]) chk(0, "R6", "spurious out_valid", 1, 0);
    end
    for (int p = 0; p < N; p++) begin
      if (act[p]) begin
        bi[p]++;
        if (bi[p] > plen[p]) act[p] = 0;
        else in_data[p] = mk(p, bi[p], salt[p]);
      end
    end
    // grants and notices
    gp = -1;
    if ($countones(gnt) > 1) chk(0, "R2", "grants in one cycle", $countones(gnt), 1);
    if ($countones(ntf_valid) != $countones(gnt))
      chk(0, "R3", "notice count", $countones(ntf_valid), $countones(gnt));
    for (int p = 0; p < N; p++) begin
      if (gnt[p]) begin
        gp = p;
        if (!pend[p]) begin
          chk(0, "R9", "grant without a valid request", p, -1);
        end else begin
          d = pdst[p];
          chk(ntf_valid[d] && ntf_src[d] == IDW'(p), "R3", "notice source", ntf_src[d], p);
          chk(ntf_type[d] == TW'(ptype[p]) && ntf_hi[d] == phi[p], "R3", "notice type/lane",
              {ntf_type[d], ntf_hi[d]}, {TW'(ptype[p]), phi[p]});
          chk(phi[p] ? dst_rdy_hi[d] : dst_rdy_lo[d], "R1", "lane ready at grant", 0, 1);
          for (int o = 0; o < N; o++)
            if (act[o] && pdst[o] == d) chk(0, "R7", "destination already receiving", o, -1);
          pend[p] = 0; req_valid[p] = 1'b0;
          act[p] = 1; bi[p] = 0; in_data[p] = mk(p, 0, salt[p]);
          nact = 0;
          for (int o = 0; o < N; o++) nact += act[o];
          if (nact > NP) chk(0, "R8", "transfers in flight", nact, NP);
        end
      end
    end
    for (int p = 0; p < N; p++) begin
      if (pend[p]) begin
        pwait[p]++;
        if (pwait[p] == 600) chk(0, "R5", "request starved", p, -1);
      end
    end
    if (rnd) begin
      for (int q = 0; q < N; q++) begin
        dst_rdy_hi[q] = ($urandom % 4) != 0;
        dst_rdy_lo[q] = ($urandom % 3) != 0;
      end
      for (int p = 0; p < N; p++)
        if (!pend[p] && !act[p] && ($urandom % 4) == 0)
          issue(p, (p + 1 + int'($urandom % (N - 1))) % N, 1'($urandom), int'($urandom % 4),
                int'($urandom % 4));
    end
  endtask

  task automatic wait_grant(output int port, output int n);
    port = -1; n = 0;
    for (int k = 0; k < 60; k++) begin
      step(); n++;
      if (gp >= 0) begin port = gp; break; end
    end
  endtask

  task automatic drain();
    bit busy;
    rnd = 0; dst_rdy_hi = '1; dst_rdy_lo = '1;
    for (int k = 0; k < 3000; k++) begin
      busy = 0;
      for (int p = 0; p < N; p++) busy |= pend[p] | act[p];
      if (!busy) break;
      step();
    end
    step(); step();
  endtask

  initial begin
    #(200000 * 4);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int port, n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = '0; req_hi = '0; req_dst = '0; req_type = '0;
    req_len = '0; in_data = '0; dst_rdy_hi = '1; dst_rdy_lo = '1;
    for (int p = 0; p < N; p++) begin pend[p] = 0; act[p] = 0; end
    // R11: outputs quiet in reset even with a request present
    req_valid[1] = 1'b1; req_dst[1] = 3'd2;
    repeat (3) @(negedge clk);
    chk(gnt == '0 && err == '0, "R11", "gnt/err in reset", {gnt, err}, 0);
    chk(ntf_valid == '0 && out_valid == '0, "R11", "ntf/out in reset", {ntf_valid, out_valid}, 0);
    req_valid = '0;
    rst_n = 1'b1;
    repeat (4) step();

    // R4 then R7: high beats low to the same destination; timing after release
    issue(1, 5, 0, 1, 0);
    issue(2, 5, 1, 2, 0);
    wait_grant(port, n);
    chk(port == 2, "R4", "high lane first", port, 2);
    wait_grant(port, n);
    chk(port == 1 && n == 3, "R7", "low grant cycles after single beat", n, 3);
    drain();

    // R5: low pointer sits after port 1
    issue(0, 1, 0, 0, 0); issue(3, 4, 0, 0, 0); issue(6, 7, 0, 0, 0);
    wait_grant(port, n);
    chk(port == 3, "R5", "first round-robin winner", port, 3);
    step(); chk(gp == 6, "R5", "second round-robin winner", gp, 6);
    step(); chk(gp == 0, "R5", "third round-robin winner", gp, 0);
    drain();

    // R8: three datapaths, four 4-beat transfers
    for (int p = 0; p < 4; p++) issue(p, p + 4, 1, 3, 3);
    wait_grant(port, n);
    chk(port == 3, "R5", "high pointer winner", port, 3);
    step(); chk(gp == 0, "R8", "second path", gp, 0);
    step(); chk(gp == 1, "R8", "third path", gp, 1);
    wait_grant(port, n);
    chk(port == 2 && n == 4, "R8", "fourth waits for a free path", n, 4);
    drain();

    // R10: low lane stalled, high lane open
    dst_rdy_lo[6] = 1'b0;
    issue(0, 6, 0, 1, 1);
    for (int k = 0; k < 4; k++) begin
      step(); chk(gp != 0, "R10", "stalled low lane granted", gp, -1);
    end
    issue(2, 6, 1, 2, 1);
    wait_grant(port, n);
    chk(port == 2, "R10", "high lane passes stalled low lane", port, 2);
    dst_rdy_lo[6] = 1'b1;
    wait_grant(port, n);
    chk(port == 0, "R10", "low lane after ready", port, 0);
    drain();

    // R12: two ports pushing to each other
    issue(1, 2, 1, 0, 3); issue(2, 1, 1, 0, 3);
    wait_grant(port, n);
    chk(port == 1, "R12", "first of crossing pair", port, 1);
    step(); chk(gp == 2, "R12", "second of crossing pair next cycle", gp, 2);
    drain();

    // R9: request to own port
    req_valid[4] = 1'b1; req_dst[4] = 3'd4; req_hi[4] = 1'b1;
    step(); chk(err[4] == 1'b1, "R9", "error pulse", err[4], 1);
    for (int k = 0; k < 4; k++) begin
      step();
      chk(err[4] == 1'b0 && gnt[4] == 1'b0, "R9", "self request quiet", {err[4], gnt[4]}, 0);
    end
    req_valid[4] = 1'b0;
    step();

    // constrained random traffic
    rnd = 1;
    repeat (4000) step();
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule